// File: doc/BRIEF.md
# Dual-Port SRAM Write Strobe Sequencer

This block sits between a clocked request source and one port of an asynchronous dual-port static RAM. It takes a single-cycle write request that carries an address, a data word and a space-select flag (storage array or semaphore cells). From that request it generates the address, both enables, the read/write strobe, the output enable and the data-bus drive enable. Every interval the RAM needs is counted in system clock cycles. Each interval is a parameter of at least one cycle.

Two write styles are supported, selected by a static mode input. In strobe-controlled mode the selected enable is held low across the cycle and read/write is pulsed. In enable-controlled mode read/write is held low and the selected enable is pulsed. A static input also sets the output-enable level. When output enable is kept low during a strobe-controlled write, the pulse is stretched and the bus drive is held back so that the RAM can release its outputs before the controller drives. A one-cycle completion pulse marks the end of write recovery.

Top module: `dpsram_wr_seq`

## Requirements
- R1: While reset is held and after it, the port is idle: `ram_ce_n`, `ram_sem_n` and `ram_rw_n` are 1, `ram_dq_oe`, `busy` and `done` are 0.
- R2: A request is taken only when the block is idle and `req_valid` is 1 at a clock edge. A request raised while `busy` is 1 changes neither `ram_addr` nor the strobes, and no write follows it.
- R3: With `req_sem`=0 the active enable is `ram_ce_n` and `ram_sem_n` stays 1. With `req_sem`=1 the active enable is `ram_sem_n` and `ram_ce_n` stays 1. The two are never both 0.
- R4: With `mode_ce`=0, the active enable is 0 with `ram_rw_n`=1 for T_AS cycles. Then `ram_rw_n` is 0 for P cycles, where P = max(T_WP, T_WZ+T_DW) if `oe_low`=1 and P = max(T_WP, T_DW) otherwise. `ram_oe_n` always equals the inverse of `oe_low`.
- R5: With `mode_ce`=1, `ram_rw_n` is 0 with the enable at 1 for T_AS cycles. Then the active enable is 0 for max(T_EW, T_DW) cycles while `ram_rw_n` stays 0.
- R6: Both strobes return to 1 at the same edge that ends the write pulse. `ram_addr` equals the accepted address from the cycle after acceptance until `done`.
- R7: `ram_dq_oe` is 1 in every pulse cycle, except the first T_WZ pulse cycles when `mode_ce`=0 and `oe_low`=1. It stays 1 for the first T_DH cycles after the pulse. While it is 1, `ram_dq_out` equals the accepted data.
- R8: After the pulse, the strobes stay at 1 for max(T_WR, T_DH) cycles. `done` is then 1 for exactly one cycle, and in that cycle `busy` is 0. `busy` is 1 from the cycle after acceptance until `done`.
- R9: A request present in the `done` cycle is accepted, and its setup phase begins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_ce | input | 1 | Static: 1 = enable-controlled, 0 = strobe-controlled write |
| oe_low | input | 1 | Static: keep RAM output enable asserted during writes |
| req_valid | input | 1 | Write request, taken when idle |
| req_sem | input | 1 | 1 = semaphore space, 0 = storage array |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse at the end of write recovery |
| ram_addr | output | AW | RAM address |
| ram_ce_n | output | 1 | RAM array enable, active low |
| ram_sem_n | output | 1 | RAM semaphore enable, active low |
| ram_rw_n | output | 1 | RAM read/write strobe, low = write |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dq_out | output | DW | Data to drive onto the RAM bus |
| ram_dq_oe | output | 1 | Drive enable for the RAM data bus |

## Verification
Cycle 1 is the cycle after the edge that takes the request. Setup occupies cycles 1 to T_AS. The pulse follows for P cycles, then recovery for max(T_WR, T_DH) cycles, and `done` falls on the cycle after recovery. The bench computes this schedule arithmetically for every mode, output-enable level and space. It compares every port at the falling edge of each cycle in the window, so each expected level is checked in exactly the cycle it is due. Back-to-back requests reuse the `done` cycle as cycle 0 of the next schedule, and an ignored request is followed by idle cycles that are checked at the strobes.

// File: rtl/dpw_pkg.sv
// Shared types for the dual-port SRAM write sequencer.
package dpw_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_PULSE = 2'd2,
        PH_REC   = 2'd3
    } phase_t;
endpackage

// File: rtl/dpw_req_capture.sv
// Holds the accepted address, data and space flag for one write.
// Assumes accept is raised only in the idle phase; the held values
// drive the RAM pins for the whole write, so they never move mid-cycle.
module dpw_req_capture #(
    parameter int AW = 8,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          req_sem,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output logic          sem_q
);
    // Load the request fields on acceptance, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            sem_q  <= 1'b0;
        end else if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
            sem_q  <= req_sem;
        end
    end
endmodule

// File: rtl/dpw_phase_ctl.sv
// Phase sequencer: idle, address setup, write pulse, recovery.
// Each phase length is a cycle count. The pulse length is picked from
// the static mode inputs, which are assumed not to change during a write.
module dpw_phase_ctl
    import dpw_pkg::*;
#(
    parameter int T_AS = 2,
    parameter int T_WP = 3,
    parameter int T_EW = 4,
    parameter int T_WZ = 2,
    parameter int T_DW = 2,
    parameter int T_DH = 1,
    parameter int T_WR = 2,
    parameter int CW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          mode_ce,
    input  logic          oe_low,
    output phase_t        phase,
    output logic [CW-1:0] idx,
    output logic          accept,
    output logic          done
);
    localparam int P_CE    = (T_EW > T_DW) ? T_EW : T_DW;
    localparam int P_RW_HI = (T_WP > T_DW) ? T_WP : T_DW;
    localparam int P_RW_LO = (T_WP > T_WZ + T_DW) ? T_WP : T_WZ + T_DW;
    localparam int R_LEN   = (T_WR > T_DH) ? T_WR : T_DH;

    logic [CW-1:0] setup_last;
    logic [CW-1:0] pulse_last;
    logic [CW-1:0] rec_last;

    // Last index of each phase for the current mode.
    always_comb begin
        setup_last = CW'(T_AS - 1);
        rec_last   = CW'(R_LEN - 1);
        if (mode_ce)
            pulse_last = CW'(P_CE - 1);
        else if (oe_low)
            pulse_last = CW'(P_RW_LO - 1);
        else
            pulse_last = CW'(P_RW_HI - 1);
    end

    assign accept = (phase == PH_IDLE) && req_valid;

    // Step through the phases and count cycles inside each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    idx <= '0;
                    if (req_valid) phase <= PH_SETUP;
                end
                PH_SETUP: begin
                    if (idx == setup_last) begin
                        phase <= PH_PULSE;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (idx == pulse_last) begin
                        phase <= PH_REC;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: begin
                    if (idx == rec_last) begin
                        phase <= PH_IDLE;
                        idx   <= '0;
                        done  <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            endcase
        end
    end

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_after_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(phase) == PH_REC);
    // R2
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && phase != PH_REC) |=> phase != PH_SETUP || $past(phase) == PH_SETUP);
endmodule

// File: rtl/dpw_strobe_gen.sv
// Decodes the phase into RAM strobes and the data-bus drive enable.
// The held strobe is low through setup and pulse; the pulsed strobe is low
// only in the pulse; both rise together at the end of the pulse.
module dpw_strobe_gen
    import dpw_pkg::*;
#(
    parameter int AW   = 8,
    parameter int DW   = 9,
    parameter int T_WZ = 2,
    parameter int T_DH = 1,
    parameter int CW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_t        phase,
    input  logic [CW-1:0] idx,
    input  logic          mode_ce,
    input  logic          oe_low,
    input  logic          sem_q,
    input  logic [AW-1:0] addr_q,
    input  logic [DW-1:0] data_q,
    output logic [AW-1:0] ram_addr,
    output logic          ram_ce_n,
    output logic          ram_sem_n,
    output logic          ram_rw_n,
    output logic          ram_oe_n,
    output logic [DW-1:0] ram_dq_out,
    output logic          ram_dq_oe
);
    logic in_setup;
    logic in_pulse;
    logic in_rec;
    logic en_low;
    logic drive_hold;
    logic drive_pulse;

    // Phase flags.
    always_comb begin
        in_setup = (phase == PH_SETUP);
        in_pulse = (phase == PH_PULSE);
        in_rec   = (phase == PH_REC);
    end

    // Strobe levels for the selected write style and space.
    always_comb begin
        if (mode_ce) begin
            en_low   = in_pulse;
            ram_rw_n = !(in_setup || in_pulse);
        end else begin
            en_low   = in_setup || in_pulse;
            ram_rw_n = !in_pulse;
        end
        ram_ce_n  = sem_q ? 1'b1 : !en_low;
        ram_sem_n = sem_q ? !en_low : 1'b1;
    end

    // Data-bus drive: held off while the RAM releases its outputs, then kept for hold.
    always_comb begin
        drive_pulse = in_pulse && (mode_ce || !oe_low || idx >= CW'(T_WZ));
        drive_hold  = in_rec && (idx < CW'(T_DH));
        ram_dq_oe   = drive_pulse || drive_hold;
    end

    assign ram_addr   = addr_q;
    assign ram_dq_out = data_q;
    assign ram_oe_n   = !oe_low;

    // R3
    one_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ce_n || ram_sem_n);
    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ram_ce_n && ram_sem_n) && !ram_rw_n && $past(!(ram_ce_n && ram_sem_n) && !ram_rw_n))
        |-> $stable(ram_addr));
    // R5
    ce_after_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ce && $fell(ram_ce_n && ram_sem_n)) |-> (!ram_rw_n && $past(!ram_rw_n)));
    // R7
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> (phase == PH_PULSE || phase == PH_REC));
endmodule

// File: rtl/dpsram_wr_seq.sv
// Write sequencer for one port of an asynchronous dual-port SRAM.
// Takes a one-cycle request when idle and plays out setup, pulse and
// recovery with parameter cycle counts (each at least one).
module dpsram_wr_seq
    import dpw_pkg::*;
#(
    parameter int AW   = 8,
    parameter int DW   = 9,
    parameter int T_AS = 2,
    parameter int T_WP = 3,
    parameter int T_EW = 4,
    parameter int T_WZ = 2,
    parameter int T_DW = 2,
    parameter int T_DH = 1,
    parameter int T_WR = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_ce,
    input  logic          oe_low,
    input  logic          req_valid,
    input  logic          req_sem,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] ram_addr,
    output logic          ram_ce_n,
    output logic          ram_sem_n,
    output logic          ram_rw_n,
    output logic          ram_oe_n,
    output logic [DW-1:0] ram_dq_out,
    output logic          ram_dq_oe
);
    localparam int M1   = (T_AS > T_WP) ? T_AS : T_WP;
    localparam int M2   = (T_EW > T_WR) ? T_EW : T_WR;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int MAXT = M3 + T_WZ + T_DW + T_DH;
    localparam int CW   = $clog2(MAXT + 1);

    phase_t        phase;
    logic [CW-1:0] idx;
    logic          accept;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          sem_q;

    dpw_phase_ctl #(
        .T_AS(T_AS), .T_WP(T_WP), .T_EW(T_EW), .T_WZ(T_WZ),
        .T_DW(T_DW), .T_DH(T_DH), .T_WR(T_WR), .CW(CW)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .mode_ce(mode_ce), .oe_low(oe_low),
        .phase(phase), .idx(idx), .accept(accept), .done(done)
    );

    dpw_req_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .req_addr(req_addr), .req_data(req_data), .req_sem(req_sem),
        .addr_q(addr_q), .data_q(data_q), .sem_q(sem_q)
    );

    dpw_strobe_gen #(
        .AW(AW), .DW(DW), .T_WZ(T_WZ), .T_DH(T_DH), .CW(CW)
    ) u_strobe (
        .clk(clk), .rst_n(rst_n), .phase(phase), .idx(idx),
        .mode_ce(mode_ce), .oe_low(oe_low), .sem_q(sem_q),
        .addr_q(addr_q), .data_q(data_q),
        .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_sem_n(ram_sem_n),
        .ram_rw_n(ram_rw_n), .ram_oe_n(ram_oe_n),
        .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe)
    );

    assign busy = (phase != PH_IDLE);

    // R8
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ram_ce_n && ram_sem_n && ram_rw_n && !ram_dq_oe));
endmodule

// File: tb/sim_dpsram_wr_seq.sv
module sim_dpsram_wr_seq;
    localparam int AW = 8, DW = 9;
    localparam int T_AS = 2, T_WP = 3, T_EW = 4, T_WZ = 2, T_DW = 2, T_DH = 1, T_WR = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_ce = 1'b0, oe_low = 1'b0, req_valid = 1'b0, req_sem = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic busy, done, ram_ce_n, ram_sem_n, ram_rw_n, ram_oe_n, ram_dq_oe;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_dq_out;

    int nchk = 0, npass = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dpsram_wr_seq #(
        .AW(AW), .DW(DW), .T_AS(T_AS), .T_WP(T_WP), .T_EW(T_EW),
        .T_WZ(T_WZ), .T_DW(T_DW), .T_DH(T_DH), .T_WR(T_WR)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .mode_ce(mode_ce), .oe_low(oe_low),
        .req_valid(req_valid), .req_sem(req_sem), .req_addr(req_addr),
        .req_data(req_data), .busy(busy), .done(done), .ram_addr(ram_addr),
        .ram_ce_n(ram_ce_n), .ram_sem_n(ram_sem_n), .ram_rw_n(ram_rw_n),
        .ram_oe_n(ram_oe_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe)
    );

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (ok) npass++;
        else $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    endtask

    task automatic check_idle(input string tag);
        chk(ram_ce_n && ram_sem_n && ram_rw_n, {tag, " strobes high"},
            {ram_ce_n, ram_sem_n, ram_rw_n}, 7);
        chk(!ram_dq_oe && !busy, {tag, " no drive, not busy"}, {ram_dq_oe, busy}, 0);
    endtask

    // Drives one request at a falling edge and checks every cycle of its schedule.
    task automatic run_txn(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic s);
        int p, r, last;
        p = mode_ce ? imax(T_EW, T_DW) : (oe_low ? imax(T_WP, T_WZ + T_DW) : imax(T_WP, T_DW));
        r = imax(T_WR, T_DH);
        last = T_AS + p + r + 1;
        req_valid = 1'b1; req_addr = a; req_data = d; req_sem = s;
        for (int i = 1; i <= last; i++) begin
            bit setup, pulse, rec, en_lo, rw_lo, oe_exp;
            @(negedge clk);
            if (i == 1) req_valid = 1'b0;
            if (i == 2) begin
                req_valid = 1'b1; req_addr = ~a; req_data = ~d; req_sem = ~s;
            end
            if (i == 3) req_valid = 1'b0;
            setup = (i <= T_AS);
            pulse = (i > T_AS) && (i <= T_AS + p);
            rec   = (i > T_AS + p) && (i < last);
            en_lo = mode_ce ? pulse : (setup || pulse);
            rw_lo = mode_ce ? (setup || pulse) : pulse;
            oe_exp = (pulse && (mode_ce || !oe_low || (i - T_AS - 1) >= T_WZ))
                  || (rec && (i - T_AS - p - 1) < T_DH);
            // R3: space selects which enable moves
            chk(ram_ce_n == (s ? 1'b1 : !en_lo), "R3 ram_ce_n", ram_ce_n, s ? 1 : int'(!en_lo));
            chk(ram_sem_n == (s ? !en_lo : 1'b1), "R3 ram_sem_n", ram_sem_n, s ? int'(!en_lo) : 1);
            // R4 / R5: setup and pulse lengths; R6: common release
            chk(ram_rw_n == !rw_lo, mode_ce ? "R5 ram_rw_n" : "R4 ram_rw_n", ram_rw_n, int'(!rw_lo));
            chk(ram_oe_n == !oe_low, "R4 ram_oe_n", ram_oe_n, int'(!oe_low));
            // R6: address held through the write
            chk(ram_addr == a, "R6 ram_addr", int'(ram_addr), int'(a));
            // R7: bus drive window and data
            chk(ram_dq_oe == oe_exp, "R7 ram_dq_oe", ram_dq_oe, int'(oe_exp));
            if (oe_exp) chk(ram_dq_out == d, "R7 ram_dq_out", int'(ram_dq_out), int'(d));
            // R8: busy and the done pulse after recovery
            chk(done == (i == last), "R8 done", done, int'(i == last));
            chk(busy == (i < last), "R8 busy", busy, int'(i < last));
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            nchk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", npass, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_idle("R1 in reset");
        chk(!done, "R1 done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");
        for (int m = 0; m < 2; m++) begin
            for (int o = 0; o < 2; o++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int k = 0; k < 4; k++) begin
                        mode_ce = m[0]; oe_low = o[0];
                        run_txn(AW'(8'h11 * (k + 1) + s), DW'(9'h0A5 + 37 * k + 5 * m), s[0]);
                        if (k == 1) begin
                            // R9: request in the done cycle starts at once
                            run_txn(AW'(8'hC3 ^ k), DW'(9'h1F0 + o), !s[0]);
                        end
                        // R2: the request raised while busy left no trace
                        for (int q = 0; q < 3; q++) begin
                            @(negedge clk);
                            check_idle("R2 ignored request");
                        end
                    end
                end
            end
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", npass, nchk);
        $finish;
    end
endmodule